// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects up to 128 level-sensitive interrupt inputs, grouped in banks of 32, and turns them into two request lines for a processor: a normal request (IRQ) and a fast request (FIQ). Each input has a mask bit and a software-trigger bit. Each input also has its own line setting that picks the output it is steered to and gives it a 6-bit urgency value. The value 0 is the most urgent.

For each output, the controller picks the most urgent pending input and latches its number. It raises the request line and keeps that number frozen until software acknowledges the output through the control register. Only then does it pick again. If the latched input goes away before the acknowledge, a flag in the active register shows it and the request drops. All state is reached through a simple word-wide register port. Writes happen on the clock edge while the write strobe is high. Reads are combinational from the address.

Top module: `prio_intc`

## Requirements
- R1: After reset, every mask bit is 1, every software-trigger bit, routing bit and urgency field is 0, both request outputs are low, and the status register (0x14) bit 0 reads 1 from the first clock edge after reset is released.
- R2: Each bank window starts at 0x80 + 0x20*bank. At +0x04 is the mask word (1 disables the input), readable and writable. Writing a word to +0x08 clears the mask bits that are 1 in that word. Writing a word to +0x0C sets the mask bits that are 1 in that word. Bits written as 0 change nothing, and both of these addresses read 0.
- R3: Writing a word to +0x10 sets software-trigger bits where the word has a 1, and writing to +0x14 clears them where the word has a 1. An input is pending when (raw input OR software bit) AND NOT mask.
- R4: Each input n has a line register at 0x100 + 4*n. Bit 0 = 1 steers the input to FIQ, and 0 steers it to IRQ. A pending input appears in the bank's +0x18 word (IRQ) or +0x1C word (FIQ) according to this bit.
- R5: Input n is bit n mod 32 of bank n/32. The bank's +0x00 word reads the raw inputs. Bank windows beyond the configured number of inputs read 0.
- R6: When several inputs are pending for one output, the one with the smallest urgency value (line register bits 7:2) wins. On a tie, the lower input number wins. The active registers (0x40 IRQ, 0x44 FIQ) report the winner in bits 6:0.
- R7: The request line rises on the clock edge after an input becomes pending while the output is free. The active number then stays frozen, even when a more urgent input arrives, until 0x48 is written with bit 0 (IRQ) or bit 1 (FIQ). The write drops that output's request at the same edge and touches only the output whose bit is set.
- R8: If the latched input stops being pending for its output before the acknowledge, the next clock edge sets bit 7 of that active register and drops the request. The acknowledge clears bit 7.
- R9: Writing 0x10 with bit 1 set is a soft reset: it returns all state to its R1 values and drops both requests. The status bit reads 0 for the cycle after that write and 1 afterwards. Bit 0 of 0x10 is a plain read/write setting bit that the soft reset clears.
- R10: The revision register at 0x00 reads the major number in bits 7:4 and the minor number in bits 3:0 (defaults 2 and 1). Writes to it have no effect.
- R11: A line register reads back its urgency in bits 7:2 and its routing in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Level interrupt inputs |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| irqReq | output | 1 | Normal request to processor |
| fiqReq | output | 1 | Fast request to processor |

## Verification
The hardest case to reach is a more urgent input that arrives while an older winner is still frozen. The stimulus latches a low-urgency input first and then raises a more urgent one. It checks that the active number does not move until the acknowledge, and that the new winner is latched on the edge after it. The lost-source flag is reached the same way: an input is latched, its raw line is pulled low before any acknowledge, and the bench reads bit 7. Arbitration is swept over pairs of inputs whose numbers and urgency values come from arithmetic sequences that include ties.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int IDX_W  = 7;
  localparam int PRI_W  = 6;
  localparam int BANK_W = 2;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_REV       = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SYSSTAT   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ACT_IRQ   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_ACT_FIQ   = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_CTRL      = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_BANK_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_CFG_BASE  = 12'h100;

  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bankRegE;

  typedef enum logic [3:0] {
    RG_NONE, RG_REV, RG_SYSCFG, RG_SYSSTAT, RG_ACT_IRQ,
    RG_ACT_FIQ, RG_CTRL, RG_BANK, RG_CFG
  } regionE;

  typedef struct packed {
    regionE              region;
    logic [BANK_W-1:0]   bank;
    bankRegE             breg;
    logic [IDX_W-1:0]    idx;
  } addrDecT;

  typedef struct packed {
    logic                maskWr;
    logic                maskClr;
    logic                maskSet;
    logic                swiSet;
    logic                swiClr;
    logic                cfgWr;
    logic [1:0]          ack;
    logic                sysWr;
    logic                softRst;
    logic [DATA_W-1:0]   data;
  } strobeT;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*PRI_W-1:0] priFlat,
  output logic                     winValid,
  output logic [IDX_W-1:0]         winIdx
);
  logic [PRI_W-1:0] bestPri;

  // Linear scan: strict less-than keeps the lower index on equal urgency.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    bestPri  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!winValid || (priFlat[i*PRI_W +: PRI_W] < bestPri))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        bestPri  = priFlat[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output addrDecT           dec,
  output strobeT            stb
);
  localparam int NUM_BANKS = NUM_SRC / 32;
  localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(32'h80 + NUM_BANKS * 32);
  localparam logic [ADDR_W-1:0] CFG_END  = ADDR_W'(32'h100 + NUM_SRC * 4);

  logic [ADDR_W-1:0] bankOff;
  logic [ADDR_W-1:0] cfgOff;

  assign bankOff = busAddr - OFS_BANK_BASE;
  assign cfgOff  = busAddr - OFS_CFG_BASE;

  always_comb begin
    dec        = '0;
    dec.region = RG_NONE;
    dec.bank   = bankOff[5 +: BANK_W];
    dec.breg   = bankRegE'(bankOff[4:2]);
    dec.idx    = cfgOff[2 +: IDX_W];
    case (busAddr)
      OFS_REV:     dec.region = RG_REV;
      OFS_SYSCFG:  dec.region = RG_SYSCFG;
      OFS_SYSSTAT: dec.region = RG_SYSSTAT;
      OFS_ACT_IRQ: dec.region = RG_ACT_IRQ;
      OFS_ACT_FIQ: dec.region = RG_ACT_FIQ;
      OFS_CTRL:    dec.region = RG_CTRL;
      default: begin
        if (busAddr >= OFS_BANK_BASE && busAddr < BANK_END)
          dec.region = RG_BANK;
        else if (busAddr >= OFS_CFG_BASE && busAddr < CFG_END)
          dec.region = RG_CFG;
      end
    endcase
  end

  always_comb begin
    stb      = '0;
    stb.data = busWrData;
    if (busWr) begin
      case (dec.region)
        RG_BANK: begin
          case (dec.breg)
            BR_MASK: stb.maskWr  = 1'b1;
            BR_MCLR: stb.maskClr = 1'b1;
            BR_MSET: stb.maskSet = 1'b1;
            BR_SSET: stb.swiSet  = 1'b1;
            BR_SCLR: stb.swiClr  = 1'b1;
            default: ;
          endcase
        end
        RG_CFG:    stb.cfgWr = 1'b1;
        RG_CTRL:   stb.ack   = busWrData[1:0];
        RG_SYSCFG: begin
          stb.sysWr   = 1'b1;
          stb.softRst = busWrData[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  addrDecT            dec,
  input  strobeT             stb,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [1:0]         holdV,
  output logic [1:0]         lostV,
  output logic [IDX_W-1:0]   actIrqNum,
  output logic [IDX_W-1:0]   actFiqNum,
  output logic [NUM_SRC-1:0] pendIrqV,
  output logic [NUM_SRC-1:0] pendFiqV
);
  localparam int NUM_BANKS = NUM_SRC / 32;

  logic [NUM_SRC-1:0]       maskR;
  logic [NUM_SRC-1:0]       swiR;
  logic [NUM_SRC-1:0]       cfgFiq;
  logic [PRI_W-1:0]         cfgPri [NUM_SRC];
  logic [NUM_SRC*PRI_W-1:0] priFlat;
  logic [NUM_SRC-1:0]       pendAll;
  logic [NUM_SRC-1:0]       pendOut [2];
  logic [1:0]               winValid;
  logic [IDX_W-1:0]         winIdx [2];
  logic [IDX_W-1:0]         actNum [2];
  logic                     autoIdle;
  logic                     resetDone;

  // Mask and software-trigger state, bank by bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR <= '1;
      swiR  <= '0;
    end else if (stb.softRst) begin
      maskR <= '1;
      swiR  <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (dec.bank == BANK_W'(b)) begin
          if (stb.maskWr)  maskR[b*32 +: 32] <= stb.data;
          if (stb.maskClr) maskR[b*32 +: 32] <= maskR[b*32 +: 32] & ~stb.data;
          if (stb.maskSet) maskR[b*32 +: 32] <= maskR[b*32 +: 32] | stb.data;
          if (stb.swiSet)  swiR[b*32 +: 32]  <= swiR[b*32 +: 32] | stb.data;
          if (stb.swiClr)  swiR[b*32 +: 32]  <= swiR[b*32 +: 32] & ~stb.data;
        end
      end
    end
  end

  // Per-line routing and urgency.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFiq <= '0;
      for (int i = 0; i < NUM_SRC; i++) cfgPri[i] <= '0;
    end else if (stb.softRst) begin
      cfgFiq <= '0;
      for (int i = 0; i < NUM_SRC; i++) cfgPri[i] <= '0;
    end else if (stb.cfgWr) begin
      cfgFiq[dec.idx] <= stb.data[0];
      cfgPri[dec.idx] <= stb.data[2 +: PRI_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoIdle  <= 1'b0;
      resetDone <= 1'b0;
    end else begin
      resetDone <= !stb.softRst;
      if (stb.softRst)    autoIdle <= 1'b0;
      else if (stb.sysWr) autoIdle <= stb.data[0];
    end
  end

  assign pendAll    = (srcIn | swiR) & ~maskR;
  assign pendOut[0] = pendAll & ~cfgFiq;
  assign pendOut[1] = pendAll & cfgFiq;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pri
      assign priFlat[i*PRI_W +: PRI_W] = cfgPri[i];
    end
    for (genvar k = 0; k < 2; k++) begin : g_arb
      intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend    (pendOut[k]),
        .priFlat (priFlat),
        .winValid(winValid[k]),
        .winIdx  (winIdx[k])
      );
    end
  endgenerate

  // Per-output holder: latch a winner, freeze it until acknowledged.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdV <= '0;
      lostV <= '0;
      for (int k = 0; k < 2; k++) actNum[k] <= '0;
    end else if (stb.softRst) begin
      holdV <= '0;
      lostV <= '0;
      for (int k = 0; k < 2; k++) actNum[k] <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (stb.ack[k]) begin
          holdV[k] <= 1'b0;
          lostV[k] <= 1'b0;
        end else if (!holdV[k]) begin
          if (winValid[k]) begin
            holdV[k]  <= 1'b1;
            actNum[k] <= winIdx[k];
          end
        end else if (!pendOut[k][actNum[k]]) begin
          lostV[k] <= 1'b1;
        end
      end
    end
  end

  assign irqReq    = holdV[0] & ~lostV[0];
  assign fiqReq    = holdV[1] & ~lostV[1];
  assign actIrqNum = actNum[0];
  assign actFiqNum = actNum[1];
  assign pendIrqV  = pendOut[0];
  assign pendFiqV  = pendOut[1];

  always_comb begin
    rdData = '0;
    case (dec.region)
      RG_REV:     rdData[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
      RG_SYSCFG:  rdData[0]   = autoIdle;
      RG_SYSSTAT: rdData[0]   = resetDone;
      RG_ACT_IRQ: rdData[7:0] = {lostV[0], actNum[0]};
      RG_ACT_FIQ: rdData[7:0] = {lostV[1], actNum[1]};
      RG_BANK: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (dec.bank == BANK_W'(b)) begin
            case (dec.breg)
              BR_RAW:  rdData = srcIn[b*32 +: 32];
              BR_MASK: rdData = maskR[b*32 +: 32];
              BR_PIRQ: rdData = pendOut[0][b*32 +: 32];
              BR_PFIQ: rdData = pendOut[1][b*32 +: 32];
              default: rdData = '0;
            endcase
          end
        end
      end
      RG_CFG: rdData[7:0] = {cfgPri[dec.idx], 1'b0, cfgFiq[dec.idx]};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqReq,
  output logic               fiqReq
);
  addrDecT            dec;
  strobeT             stb;
  logic [1:0]         holdV;
  logic [1:0]         lostV;
  logic [IDX_W-1:0]   actIrqNum;
  logic [IDX_W-1:0]   actFiqNum;
  logic [NUM_SRC-1:0] pendIrqV;
  logic [NUM_SRC-1:0] pendFiqV;

  intc_control #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .dec      (dec),
    .stb      (stb)
  );

  intc_datapath #(
    .NUM_SRC  (NUM_SRC),
    .REV_MAJOR(REV_MAJOR),
    .REV_MINOR(REV_MINOR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .dec      (dec),
    .stb      (stb),
    .rdData   (busRdData),
    .irqReq   (irqReq),
    .fiqReq   (fiqReq),
    .holdV    (holdV),
    .lostV    (lostV),
    .actIrqNum(actIrqNum),
    .actFiqNum(actFiqNum),
    .pendIrqV (pendIrqV),
    .pendFiqV (pendFiqV)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic               irqReq,
  input logic               fiqReq,
  input logic [1:0]         holdV,
  input logic [1:0]         lostV,
  input logic [IDX_W-1:0]   actIrqNum,
  input logic [IDX_W-1:0]   actFiqNum,
  input logic [NUM_SRC-1:0] pendIrqV,
  input logic [NUM_SRC-1:0] pendFiqV
);
  logic ackI, ackF, srst;
  assign ackI = busWr && (busAddr == OFS_CTRL) && busWrData[0];
  assign ackF = busWr && (busAddr == OFS_CTRL) && busWrData[1];
  assign srst = busWr && (busAddr == OFS_SYSCFG) && busWrData[1];

  AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    holdV[0] && !ackI && !srst |=> $stable(actIrqNum)); // R7
  AST_FIQ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    holdV[1] && !ackF && !srst |=> $stable(actFiqNum)); // R7
  AST_IRQ_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ackI |=> !irqReq); // R7
  AST_FIQ_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ackF |=> !fiqReq); // R7
  AST_IRQ_RISE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(|pendIrqV)); // R7
  AST_IRQ_LOST_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    holdV[0] && !pendIrqV[actIrqNum] && !ackI && !srst |=> !irqReq && lostV[0]); // R8
  AST_FIQ_LOST_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    holdV[1] && !pendFiqV[actFiqNum] && !ackF && !srst |=> !fiqReq && lostV[1]); // R8
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    srst |=> !irqReq && !fiqReq); // R9
endmodule

bind prio_intc intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .irqReq   (irqReq),
  .fiqReq   (fiqReq),
  .holdV    (holdV),
  .lostV    (lostV),
  .actIrqNum(actIrqNum),
  .actFiqNum(actFiqNum),
  .pendIrqV (pendIrqV),
  .pendFiqV (pendFiqV)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  localparam int NSRC = 96;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic            busWr = 1'b0;
  logic [11:0]     busAddr = '0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic            irqReq, fiqReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_intc #(.NUM_SRC(NSRC)) i_prio_intc (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq), .fiqReq(fiqReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [11:0] bankAddr(input int bank, input int off);
    return 12'(32'h80 + bank * 32 + off);
  endfunction

  function automatic logic [11:0] cfgAddr(input int n);
    return 12'(32'h100 + n * 4);
  endfunction

  task automatic cleanSlate();
    @(negedge clk);
    srcIn = '0;
    wr(12'h048, 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int b = 0; b < 3; b++) begin
      rd(bankAddr(b, 4), v);  chk("R1 mask reset", v, 32'hFFFF_FFFF);
      rd(bankAddr(b, 24), v); chk("R1 pending reset", v, 32'h0);
    end
    rd(cfgAddr(7), v);  chk("R1 line reset", v, 32'h0);
    rd(12'h014, v);     chk("R1 status done", v, 32'h1);
    chk("R1 irq low", {31'b0, irqReq}, 32'h0);
    chk("R1 fiq low", {31'b0, fiqReq}, 32'h0);

    // R10 revision, read-only
    rd(12'h000, v); chk("R10 revision", v, 32'h21);
    wr(12'h000, 32'hFF); rd(12'h000, v); chk("R10 revision write ignored", v, 32'h21);

    // R5 bank mapping sweep
    for (int n = 0; n < NSRC; n++) begin
      @(negedge clk);
      srcIn = '0; srcIn[n] = 1'b1;
      rd(bankAddr(n / 32, 0), v);
      chk("R5 raw bit position", v, 32'h1 << (n % 32));
      rd(bankAddr((n / 32 + 1) % 3, 0), v);
      chk("R5 other bank zero", v, 32'h0);
    end
    rd(bankAddr(3, 0), v); chk("R5 absent bank reads zero", v, 32'h0);
    @(negedge clk); srcIn = '0;

    // R2 mask write, clear, set
    wr(bankAddr(0, 4), 32'hA5A5_A5A5);
    rd(bankAddr(0, 4), v); chk("R2 mask write", v, 32'hA5A5_A5A5);
    wr(bankAddr(0, 8), 32'h0000_000F);
    rd(bankAddr(0, 4), v); chk("R2 mask clear", v, 32'hA5A5_A5A0);
    wr(bankAddr(0, 12), 32'h0000_0030);
    rd(bankAddr(0, 4), v); chk("R2 mask set", v, 32'hA5A5_A5B0);
    wr(bankAddr(0, 8), 32'h0); wr(bankAddr(0, 12), 32'h0);
    rd(bankAddr(0, 4), v); chk("R2 zero write no effect", v, 32'hA5A5_A5B0);
    rd(bankAddr(0, 8), v);  chk("R2 clear reads zero", v, 32'h0);
    rd(bankAddr(0, 12), v); chk("R2 set reads zero", v, 32'h0);

    // R3 software trigger and pending formula
    for (int p = 0; p < 4; p++) begin
      logic [31:0] s, r, m;
      s = 32'h1357_9BDF * (p + 1);
      r = 32'h0F0F_3C3C ^ (32'h1111_1111 * p);
      m = 32'hFF00_FF00 >> (p * 4);
      wr(bankAddr(1, 4), m);
      wr(bankAddr(1, 20), 32'hFFFF_FFFF);
      wr(bankAddr(1, 16), s);
      @(negedge clk); srcIn[63:32] = r;
      rd(bankAddr(1, 24), v); chk("R3 pending irq", v, (r | s) & ~m);
      wr(bankAddr(1, 20), s & 32'h0000_FFFF);
      rd(bankAddr(1, 24), v); chk("R3 software clear", v, (r | (s & 32'hFFFF_0000)) & ~m);
      wr(bankAddr(1, 16), 32'h0);
      rd(bankAddr(1, 24), v); chk("R3 zero set no effect", v, (r | (s & 32'hFFFF_0000)) & ~m);
    end
    wr(bankAddr(1, 20), 32'hFFFF_FFFF);
    for (int b = 0; b < 3; b++) wr(bankAddr(b, 4), 32'h0);
    cleanSlate();

    // R4 routing to FIQ
    wr(cfgAddr(40), 32'h1);
    @(negedge clk); srcIn[40] = 1'b1;
    rd(bankAddr(1, 28), v); chk("R4 pending fiq", v, 32'h100);
    rd(bankAddr(1, 24), v); chk("R4 pending irq empty", v, 32'h0);
    @(negedge clk);
    chk("R4 fiq raised", {31'b0, fiqReq}, 32'h1);
    chk("R4 irq quiet", {31'b0, irqReq}, 32'h0);
    rd(12'h044, v); chk("R4 active fiq", v, 32'd40);
    wr(cfgAddr(40), 32'h0);
    cleanSlate();

    // R11 line readback
    wr(cfgAddr(95), 32'hFFFF_FFFF);
    rd(cfgAddr(95), v); chk("R11 line readback", v, 32'hFD);
    wr(cfgAddr(95), 32'h0);

    // R6 arbitration sweep
    for (int k = 0; k < 24; k++) begin
      int a, b, pa, pb, ex;
      a = (k * 5 + 1) % NSRC; b = (k * 7 + 3) % NSRC;
      pa = (k * 13) % 64;     pb = (k % 3 == 0) ? pa : (k * 11) % 64;
      if (a == b) continue;
      ex = (pa < pb) ? a : (pb < pa) ? b : ((a < b) ? a : b);
      wr(cfgAddr(a), 32'(pa << 2));
      wr(cfgAddr(b), 32'(pb << 2));
      cleanSlate();
      srcIn[a] = 1'b1; srcIn[b] = 1'b1;
      @(negedge clk);
      chk("R6 request raised", {31'b0, irqReq}, 32'h1);
      rd(12'h040, v); chk("R6 winner", v, 32'(ex));
      wr(cfgAddr(a), 32'h0); wr(cfgAddr(b), 32'h0);
      cleanSlate();
    end

    // R7 frozen until acknowledge, outputs independent
    wr(cfgAddr(10), 32'(20 << 2));
    wr(cfgAddr(70), 32'(1 << 2));
    @(negedge clk); srcIn[10] = 1'b1;
    @(negedge clk); srcIn[70] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h040, v); chk("R7 frozen winner", v, 32'd10);
    chk("R7 request held", {31'b0, irqReq}, 32'h1);
    wr(12'h048, 32'h1);
    chk("R7 ack drops request", {31'b0, irqReq}, 32'h0);
    @(negedge clk);
    rd(12'h040, v); chk("R7 new winner after ack", v, 32'd70);
    wr(cfgAddr(5), 32'h1 | (3 << 2));
    @(negedge clk); srcIn[5] = 1'b1;
    @(negedge clk);
    rd(12'h044, v); chk("R7 fiq winner", v, 32'd5);
    wr(12'h048, 32'h2);
    rd(12'h040, v); chk("R7 fiq ack leaves irq", v, 32'd70);
    chk("R7 irq still up", {31'b0, irqReq}, 32'h1);
    wr(cfgAddr(5), 32'h0); wr(cfgAddr(10), 32'h0); wr(cfgAddr(70), 32'h0);
    cleanSlate();

    // R8 source lost before acknowledge
    @(negedge clk); srcIn[20] = 1'b1;
    @(negedge clk);
    chk("R8 latched", {31'b0, irqReq}, 32'h1);
    srcIn[20] = 1'b0;
    @(negedge clk);
    chk("R8 request dropped", {31'b0, irqReq}, 32'h0);
    rd(12'h040, v); chk("R8 lost flag", v, 32'h80 | 32'd20);
    wr(12'h048, 32'h1);
    rd(12'h040, v); chk("R8 ack clears flag", v, 32'd20);

    // R9 setting bit and soft reset
    wr(12'h010, 32'h1);
    rd(12'h010, v); chk("R9 setting bit", v, 32'h1);
    wr(cfgAddr(33), 32'h1 | (9 << 2));
    @(negedge clk); srcIn[20] = 1'b1;
    @(negedge clk);
    chk("R9 busy before reset", {31'b0, irqReq}, 32'h1);
    wr(12'h010, 32'h2);
    rd(12'h014, v); chk("R9 status low after reset", v, 32'h0);
    chk("R9 irq dropped", {31'b0, irqReq}, 32'h0);
    rd(bankAddr(0, 4), v); chk("R9 mask restored", v, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R9 setting cleared", v, 32'h0);
    rd(cfgAddr(33), v); chk("R9 line cleared", v, 32'h0);
    @(negedge clk);
    rd(12'h014, v); chk("R9 status back high", v, 32'h1);
    chk("R9 irq stays low", {31'b0, irqReq}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule